// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block brings an SDRAM device out of power-up and then keeps it refreshed. After reset it waits a fixed number of clock cycles, the supply and clock settling time. It then issues a precharge of all banks and a mode-register load, followed by eight auto-refresh commands and a second mode-register load. Some devices accept the mode setting only after refresh, so the second load covers them. It finishes with ten read-then-write-back accesses to consecutive words, which warm up the device. Only then does it raise its ready output.

Commands leave through a simple valid/acknowledge port toward an SDRAM command issuer. Each command is held until it is acknowledged. A programmable number of idle cycles follows before the next command. Once ready, a prescaled timer adds four refreshes to a pending count at every expiry, and the sequencer drains that count through the same port. The slow-refresh input doubles the prescaler division at run time, which halves the refresh rate for small devices.

Top module: `sdr_pwrup_refresh_seq`

## Requirements
- R1: While reset is asserted, and on the cycle after it is asserted mid-run, `cmd_valid` and `mem_ready` are low.
- R2: No command is presented until at least PWRUP_CYC clock cycles after reset is released (default 10000, i.e. 200 us at 50 MHz).
- R3: The first command is precharge-all (code 1, address bit 10 set, 0x400). The second is mode-register-set (code 2) with the mode value 0x22 shifted left by 2 (address 0x088).
- R4: Eight auto-refresh commands (code 3, address 0) follow, then a second mode-register-set with address 0x088.
- R5: Ten warm-up pairs follow. Each pair is a read (code 4) and then a write (code 5) to byte address 4*i, for i = 0 to 9.
- R6: A presented command keeps `cmd_valid`, `cmd_code` and `cmd_addr` stable until a cycle with `cmd_ack` high. `cmd_valid` is low on the following cycle.
- R7: After an acknowledged command, `cmd_valid` stays low for at least MIN_GAP cycles (default 2).
- R8: `mem_ready` rises only after the last warm-up write is acknowledged (31 commands in total). Once high it stays high until reset.
- R9: With `slow_refresh` low, bursts of four auto-refresh commands begin exactly 8*195 = 1560 cycles apart.
- R10: With `slow_refresh` high, bursts begin exactly 16*195 = 3120 cycles apart. The change takes effect without a reset.
- R11: The refresh timer is held until `mem_ready` rises. The first periodic refresh comes no earlier than one full period after `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slow_refresh | input | 1 | High selects the halved refresh rate |
| cmd_ack | input | 1 | Command issuer accepts the presented command |
| cmd_valid | output | 1 | A command is presented |
| cmd_code | output | 3 | 0 none, 1 precharge-all, 2 mode set, 3 auto-refresh, 4 read, 5 write |
| cmd_addr | output | ADDR_W | Address field of the command |
| mem_ready | output | 1 | Initialisation complete |

## Verification
The acknowledge latency is varied from zero to three cycles. This exposes a design that drops or changes a command before acknowledge, issues a command twice, or skips the idle gap.

The command order is compared entry by entry against a table. A sequencer that issues the mode load only once, miscounts the refreshes, or gets the warm-up addressing wrong fails on a specific table index.

Burst spacing is measured exactly in both rate settings. A prescaler that ignores the rate input, or a period off by one tick, shows up as a wrong interval.

Reset is applied mid-run. The check watches that no command appears during the restarted power-up wait and that ready falls.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NONE    = 3'd0,
    CMD_PRE_ALL = 3'd1,
    CMD_MODE    = 3'd2,
    CMD_AREF    = 3'd3,
    CMD_RD      = 3'd4,
    CMD_WR      = 3'd5
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_PRE,
    ST_MODE_A,
    ST_AREF,
    ST_MODE_B,
    ST_WARM,
    ST_DRAIN,
    ST_RUN
  } seq_state_e;

endpackage

// File: rtl/sdr_cmd_port.sv
module sdr_cmd_port
  import sdr_seq_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int MIN_GAP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  sdr_cmd_e          issue_code,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic              cmd_ack,
  output logic              cmd_valid,
  output logic [2:0]        cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              port_idle
);

  localparam int GAP_W = $clog2(MIN_GAP + 2);

  logic              busy_q, busy_d;
  sdr_cmd_e          code_q, code_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [GAP_W-1:0]  gap_q, gap_d;

  assign port_idle = !busy_q && (gap_q == '0);

  always_comb begin
    busy_d = busy_q;
    code_d = code_q;
    addr_d = addr_q;
    gap_d  = gap_q;
    if (busy_q && cmd_ack) begin
      busy_d = 1'b0;
      gap_d  = GAP_W'(MIN_GAP);
    end else if (!busy_q && (gap_q != '0)) begin
      gap_d = gap_q - 1'b1;
    end
    if (issue) begin
      busy_d = 1'b1;
      code_d = issue_code;
      addr_d = issue_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      code_q <= CMD_NONE;
      addr_q <= '0;
      gap_q  <= '0;
    end else begin
      busy_q <= busy_d;
      gap_q  <= gap_d;
      if (issue) begin
        code_q <= code_d;
        addr_q <= addr_d;
      end
    end
  end

  assign cmd_valid = busy_q;
  assign cmd_code  = busy_q ? code_q : CMD_NONE;
  assign cmd_addr  = busy_q ? addr_q : '0;

endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
  parameter int PRE_FAST     = 8,
  parameter int PRE_SLOW     = 16,
  parameter int PERIOD_TICKS = 195
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow,
  output logic expire
);

  localparam int PRE_W = $clog2(PRE_SLOW + 1);
  localparam int PER_W = $clog2(PERIOD_TICKS + 1);

  logic [PRE_W-1:0] pre_q, pre_d, div_last;
  logic [PER_W-1:0] per_q, per_d;
  logic             tick, per_last;

  always_comb begin
    div_last = slow ? PRE_W'(PRE_SLOW - 1) : PRE_W'(PRE_FAST - 1);
    tick     = run && (pre_q >= div_last);
    per_last = (per_q == PER_W'(PERIOD_TICKS - 1));
    expire   = tick && per_last;
    if (!run) begin
      pre_d = '0;
      per_d = '0;
    end else if (tick) begin
      pre_d = '0;
      per_d = per_last ? '0 : per_q + 1'b1;
    end else begin
      pre_d = pre_q + 1'b1;
      per_d = per_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      per_q <= '0;
    end else begin
      pre_q <= pre_d;
      per_q <= per_d;
    end
  end

endmodule

// File: rtl/sdr_seq_ctrl.sv
module sdr_seq_ctrl
  import sdr_seq_pkg::*;
#(
  parameter int          ADDR_W        = 13,
  parameter int          PWRUP_CYC     = 10000,
  parameter int          INIT_REFS     = 8,
  parameter int          WARM_WORDS    = 10,
  parameter int          REFS_PER_TICK = 4,
  parameter logic [7:0]  MODE_VAL      = 8'h22,
  parameter int          WORD_SHIFT    = 2,
  parameter int          PRE_ALL_BIT   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_idle,
  input  logic              expire,
  output logic              issue,
  output sdr_cmd_e          issue_code,
  output logic [ADDR_W-1:0] issue_addr,
  output logic              ready
);

  localparam int PW_W     = $clog2(PWRUP_CYC + 1);
  localparam int IDX_MAX  = (INIT_REFS > 2 * WARM_WORDS) ? INIT_REFS : 2 * WARM_WORDS;
  localparam int IDX_W    = $clog2(IDX_MAX + 1);
  localparam int PEND_W   = $clog2(4 * REFS_PER_TICK + 1);
  localparam int PEND_MAX = (1 << PEND_W) - 1;

  seq_state_e        st_q, st_d;
  logic [PW_W-1:0]   wait_q, wait_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic              run_ref;

  always_comb begin
    st_d       = st_q;
    wait_d     = wait_q;
    idx_d      = idx_q;
    issue      = 1'b0;
    issue_code = CMD_NONE;
    issue_addr = '0;
    run_ref    = 1'b0;
    case (st_q)
      ST_PWRUP: begin
        if (wait_q == PW_W'(PWRUP_CYC - 1)) st_d = ST_PRE;
        else                                wait_d = wait_q + 1'b1;
      end
      ST_PRE: if (port_idle) begin
        issue      = 1'b1;
        issue_code = CMD_PRE_ALL;
        issue_addr = ADDR_W'(1) << PRE_ALL_BIT;
        st_d       = ST_MODE_A;
      end
      ST_MODE_A: if (port_idle) begin
        issue      = 1'b1;
        issue_code = CMD_MODE;
        issue_addr = ADDR_W'(MODE_VAL) << WORD_SHIFT;
        idx_d      = '0;
        st_d       = ST_AREF;
      end
      ST_AREF: if (port_idle) begin
        issue      = 1'b1;
        issue_code = CMD_AREF;
        idx_d      = idx_q + 1'b1;
        if (idx_q == IDX_W'(INIT_REFS - 1)) st_d = ST_MODE_B;
      end
      ST_MODE_B: if (port_idle) begin
        issue      = 1'b1;
        issue_code = CMD_MODE;
        issue_addr = ADDR_W'(MODE_VAL) << WORD_SHIFT;
        idx_d      = '0;
        st_d       = ST_WARM;
      end
      ST_WARM: if (port_idle) begin
        issue      = 1'b1;
        issue_code = idx_q[0] ? CMD_WR : CMD_RD;
        issue_addr = ADDR_W'(idx_q >> 1) << WORD_SHIFT;
        idx_d      = idx_q + 1'b1;
        if (idx_q == IDX_W'(2 * WARM_WORDS - 1)) st_d = ST_DRAIN;
      end
      ST_DRAIN: if (port_idle) st_d = ST_RUN;
      ST_RUN: if (port_idle && (pend_q != '0)) begin
        issue      = 1'b1;
        issue_code = CMD_AREF;
        run_ref    = 1'b1;
      end
      default: st_d = ST_PWRUP;
    endcase

    pend_d = pend_q;
    if (run_ref) pend_d = pend_d - 1'b1;
    if (expire) begin
      if (pend_d > PEND_W'(PEND_MAX - REFS_PER_TICK)) pend_d = PEND_W'(PEND_MAX);
      else                                           pend_d = pend_d + PEND_W'(REFS_PER_TICK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PWRUP;
      wait_q <= '0;
      idx_q  <= '0;
      pend_q <= '0;
    end else begin
      st_q   <= st_d;
      wait_q <= wait_d;
      idx_q  <= idx_d;
      pend_q <= pend_d;
    end
  end

  assign ready = (st_q == ST_RUN);

endmodule

// File: rtl/sdr_pwrup_refresh_seq.sv
module sdr_pwrup_refresh_seq
  import sdr_seq_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int PWRUP_CYC     = 10000,
  parameter int MIN_GAP       = 2,
  parameter int INIT_REFS     = 8,
  parameter int WARM_WORDS    = 10,
  parameter int REFS_PER_TICK = 4,
  parameter int PRE_FAST      = 8,
  parameter int PRE_SLOW      = 16,
  parameter int PERIOD_TICKS  = 195
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_refresh,
  input  logic              cmd_ack,
  output logic              cmd_valid,
  output logic [2:0]        cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              mem_ready
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              port_idle, issue, expire;
  sdr_cmd_e          issue_code;
  logic [ADDR_W-1:0] issue_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sdr_seq_ctrl #(
    .ADDR_W(ADDR_W), .PWRUP_CYC(PWRUP_CYC), .INIT_REFS(INIT_REFS),
    .WARM_WORDS(WARM_WORDS), .REFS_PER_TICK(REFS_PER_TICK)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_int_n), .port_idle(port_idle), .expire(expire),
    .issue(issue), .issue_code(issue_code), .issue_addr(issue_addr),
    .ready(mem_ready)
  );

  sdr_cmd_port #(.ADDR_W(ADDR_W), .MIN_GAP(MIN_GAP)) i_port (
    .clk(clk), .rst_n(rst_int_n), .issue(issue), .issue_code(issue_code),
    .issue_addr(issue_addr), .cmd_ack(cmd_ack), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr), .port_idle(port_idle)
  );

  sdr_refresh_timer #(
    .PRE_FAST(PRE_FAST), .PRE_SLOW(PRE_SLOW), .PERIOD_TICKS(PERIOD_TICKS)
  ) i_timer (
    .clk(clk), .rst_n(rst_int_n), .run(mem_ready), .slow(slow_refresh),
    .expire(expire)
  );

endmodule

// File: rtl/sdr_seq_checker.sv
module sdr_seq_checker #(
  parameter int ADDR_W    = 13,
  parameter int PWRUP_CYC = 10000,
  parameter int MIN_GAP   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ack,
  input logic              cmd_valid,
  input logic [2:0]        cmd_code,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              mem_ready
);

  logic [31:0] since_q, idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      idle_q  <= '0;
    end else begin
      if (since_q != 32'hFFFF_FFFF) since_q <= since_q + 1;
      if (cmd_valid && cmd_ack)                      idle_q <= '0;
      else if (!cmd_valid && idle_q != 32'hFFFF_FFFF) idle_q <= idle_q + 1;
    end
  end

  assert_pwrup_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> since_q >= 32'(PWRUP_CYC));

  assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ack |=> cmd_valid && $stable(cmd_code) && $stable(cmd_addr));

  assert_min_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> idle_q >= 32'(MIN_GAP));

  assert_ready_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ready |=> mem_ready);

endmodule

bind sdr_pwrup_refresh_seq sdr_seq_checker #(
  .ADDR_W(ADDR_W), .PWRUP_CYC(PWRUP_CYC), .MIN_GAP(MIN_GAP)
) i_seq_checker (
  .clk(clk), .rst_n(rst_n), .cmd_ack(cmd_ack), .cmd_valid(cmd_valid),
  .cmd_code(cmd_code), .cmd_addr(cmd_addr), .mem_ready(mem_ready)
);

// File: tb/test_sdr_pwrup_refresh_seq.sv
module test_sdr_pwrup_refresh_seq;

  localparam int CLK_PERIOD = 20;
  localparam int PWRUP_CYC  = 10000;
  localparam int MIN_GAP    = 2;
  localparam int FAST_IVL   = 8 * 195;
  localparam int SLOW_IVL   = 16 * 195;
  localparam int N_INIT     = 31;
  localparam int LOG_N      = 128;

  // {code[2:0], addr[12:0]} for the initialisation sequence
  localparam logic [15:0] EXP_SEQ [N_INIT] = '{
    16'h2400, 16'h4088,
    16'h6000, 16'h6000, 16'h6000, 16'h6000, 16'h6000, 16'h6000, 16'h6000, 16'h6000,
    16'h4088,
    16'h8000, 16'hA000, 16'h8004, 16'hA004, 16'h8008, 16'hA008, 16'h800C, 16'hA00C,
    16'h8010, 16'hA010, 16'h8014, 16'hA014, 16'h8018, 16'hA018, 16'h801C, 16'hA01C,
    16'h8020, 16'hA020, 16'h8024, 16'hA024
  };

  logic        clk, rst_n, slow_refresh, cmd_ack;
  logic        cmd_valid, mem_ready;
  logic [2:0]  cmd_code;
  logic [12:0] cmd_addr;

  int checks, errors, cyc, log_n, first_v;
  logic [2:0]  log_code [LOG_N];
  logic [12:0] log_addr [LOG_N];
  int          log_cyc  [LOG_N];

  sdr_pwrup_refresh_seq i_sdr_pwrup_refresh_seq (
    .clk(clk), .rst_n(rst_n), .slow_refresh(slow_refresh), .cmd_ack(cmd_ack),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
    .mem_ready(mem_ready)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // command issuer model: acknowledge latency of 0..3 cycles
  initial begin : responder
    int  wcnt, idle;
    bit  seen;
    logic [2:0]  h_code;
    logic [12:0] h_addr;
    cmd_ack = 1'b0; wcnt = 0; idle = 0; seen = 0; h_code = '0; h_addr = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        cmd_ack = 1'b0; wcnt = 0; idle = 0; seen = 0;
      end else if (cmd_ack) begin
        cmd_ack = 1'b0;
        chk(!cmd_valid, "R6 valid after ack", int'(cmd_valid), 0);
      end else if (cmd_valid) begin
        if (!seen) begin
          if (first_v < 0) first_v = cyc;
          if (log_n > 0) chk(idle >= MIN_GAP, "R7 gap", idle, MIN_GAP);
          h_code = cmd_code; h_addr = cmd_addr; seen = 1;
        end else begin
          chk(cmd_code == h_code && cmd_addr == h_addr, "R6 hold",
              {cmd_code, cmd_addr}, {h_code, h_addr});
        end
        if (wcnt >= log_n % 4) begin
          cmd_ack = 1'b1;
          if (log_n < LOG_N) begin
            log_code[log_n] = cmd_code;
            log_addr[log_n] = cmd_addr;
            log_cyc[log_n]  = cyc;
          end
          log_n++;
          wcnt = 0; seen = 0; idle = 0;
        end else begin
          wcnt++;
        end
      end else begin
        idle++;
      end
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin : main
    int rel_cyc, ready_cyc, n0, n1, t;
    checks = 0; errors = 0; cyc = 0; log_n = 0; first_v = -1;
    rst_n = 1'b0; slow_refresh = 1'b0;
    repeat (3) @(negedge clk);
    chk(!cmd_valid, "R1 valid in reset", int'(cmd_valid), 0);
    chk(!mem_ready, "R1 ready in reset", int'(mem_ready), 0);
    rst_n = 1'b1;
    rel_cyc = cyc;

    t = 0;
    while (!mem_ready && t < 20000) begin @(negedge clk); t++; end
    ready_cyc = cyc;
    chk(mem_ready, "R8 ready reached", int'(mem_ready), 1);
    chk(log_n == N_INIT, "R8 commands before ready", log_n, N_INIT);
    chk(first_v - rel_cyc >= PWRUP_CYC, "R2 power-up wait", first_v - rel_cyc, PWRUP_CYC);

    for (int i = 0; i < N_INIT; i++) begin
      string tag;
      tag = (i < 2) ? "R3 sequence" : (i < 11) ? "R4 sequence" : "R5 sequence";
      chk({log_code[i], log_addr[i]} == EXP_SEQ[i], tag,
          {log_code[i], log_addr[i]}, EXP_SEQ[i]);
    end

    t = 0;
    while (log_n < N_INIT + 16 && t < 20000) begin @(negedge clk); t++; end
    chk(log_n >= N_INIT + 16, "R9 fast bursts seen", log_n, N_INIT + 16);
    chk(log_cyc[N_INIT] - ready_cyc >= FAST_IVL, "R11 first refresh",
        log_cyc[N_INIT] - ready_cyc, FAST_IVL);
    for (int k = 0; k < 3; k++)
      chk(log_cyc[N_INIT + 4*(k+1)] - log_cyc[N_INIT + 4*k] == FAST_IVL, "R9 interval",
          log_cyc[N_INIT + 4*(k+1)] - log_cyc[N_INIT + 4*k], FAST_IVL);
    for (int i = N_INIT; i < N_INIT + 16; i++)
      chk(log_code[i] == 3'd3, "R9 refresh code", log_code[i], 3);

    repeat (20) @(negedge clk);
    slow_refresh = 1'b1;
    n0 = log_n;
    t = 0;
    while (log_n < n0 + 16 && t < 40000) begin @(negedge clk); t++; end
    chk(log_n >= n0 + 16, "R10 slow bursts seen", log_n, n0 + 16);
    for (int j = 1; j < 3; j++)
      chk(log_cyc[n0 + 4*(j+1)] - log_cyc[n0 + 4*j] == SLOW_IVL, "R10 interval",
          log_cyc[n0 + 4*(j+1)] - log_cyc[n0 + 4*j], SLOW_IVL);
    chk(mem_ready, "R8 ready held", int'(mem_ready), 1);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!cmd_valid, "R1 valid after mid-run reset", int'(cmd_valid), 0);
    chk(!mem_ready, "R1 ready after mid-run reset", int'(mem_ready), 0);
    rst_n = 1'b1;
    n1 = log_n;
    repeat (1000) @(negedge clk);
    chk(log_n == n1, "R2 quiet during restart wait", log_n, n1);
    chk(!mem_ready, "R8 ready low during restart", int'(mem_ready), 0);

    finish_run();
  end

endmodule